// File: doc/BRIEF.md
# Up/Down Timer with Pulse-Width Output

A general-purpose timer counter of parameterizable width (16 bits by default). It counts up or down while enabled. It raises a sticky timeout flag each time it passes the end of its range. It records the count when an external event arrives, and it drives one pulse-width output. The external event input is asynchronous. It is synchronized and edge-detected inside the block. The event can capture the running count, restart the counter, or do both at once.

The output works in one of two modes. In toggle mode it inverts on every timeout. In match mode it goes active when the count equals a programmed match value, and it drops back to its idle level on the next timeout. The idle level is a separate input, so the output can be made active-high or active-low. Configuration is taken directly from input pins. A bus wrapper that holds the control registers, and any clock-domain crossing, sit outside this block.

Top module: `updn_pwm_timer`

## Requirements
- R1: A timeout event occurs in an enabled, counting cycle in which the count is at its terminal value: all ones with `count_up`=1, or zero with `count_up`=0. At that clock edge the counter reloads 0 when counting up, or `load_val` when counting down. Otherwise it steps by one in the selected direction. After reset the count is 0.
- R2: `timeout_flag` sets on the edge that ends a timeout cycle and stays set until `clr_irq` is high at an edge with no timeout in the same cycle. A timeout wins over a simultaneous clear.
- R3: In match mode (`pwm_match_mode`=1), the output leaves its idle level at the edge that ends a counting cycle in which the count equals `match_val`.
- R4: In match mode the output returns to idle at the edge that ends a timeout cycle. A match that coincides with the timeout cycle, or a match value that is never reached, leaves the output idle for that period.
- R5: In toggle mode (`pwm_match_mode`=0), the output inverts at the edge that ends each timeout cycle. It starts at the idle level after reset.
- R6: `pwm_out` equals `pwm_idle_lvl` when inactive and its inverse when active, so `pwm_idle_lvl`=1 inverts the waveform.
- R7: `event_in` passes through a two-flop synchronizer and a rising-edge detector. When `evt_capture_en`=1, the count of the cycle in which the edge is detected is latched into `cap_value` (three edges after `event_in` rises), and `cap_pending` sets. `cap_pending` holds until `clr_cap` is high with no capture in the same cycle. A level held high captures only once. With `evt_capture_en`=0 nothing is captured.
- R8: When `evt_reset_en`=1, a detected event reloads the counter: 0 when counting up, `load_val` when counting down. `cnt_rst_busy` is then 1 for exactly one cycle, during which the counter holds and no timeout or match occurs. An event reset takes priority over a timeout in the same cycle.
- R9: After reset, `pwm_out` equals the idle level, and `timeout_flag`, `cap_pending`, `cap_value` and `cnt_rst_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Count enable |
| count_up | input | 1 | Direction: 1 up, 0 down |
| load_val | input | W | Reload value for down counting |
| event_in | input | 1 | Asynchronous event / capture strobe |
| evt_capture_en | input | 1 | Event captures the count |
| evt_reset_en | input | 1 | Event restarts the counter |
| clr_irq | input | 1 | Clears the timeout flag |
| clr_cap | input | 1 | Clears the capture-pending flag |
| pwm_match_mode | input | 1 | Output mode: 0 toggle, 1 match |
| pwm_idle_lvl | input | 1 | Output level when inactive |
| match_val | input | W | Match value for match mode |
| pwm_out | output | 1 | Pulse-width output |
| timeout_flag | output | 1 | Sticky timeout flag |
| cap_pending | output | 1 | Sticky capture-pending flag |
| cap_value | output | W | Last captured count |
| cnt_rst_busy | output | 1 | Event reset in progress |

## Verification
The bench builds the timer with an 8-bit counter. This makes a full up-count period 256 cycles long, so wrap-around timeouts and up-count match behaviour are reached within a short run. Down counting uses a small load value. That makes coincident, unreachable and end-of-range match values quick to exercise in both idle polarities. Because there is no count output, the count is observed through captures, which also confirm the hold cycle that follows an event reset.

// File: rtl/timer_pkg.sv
// Package: shared encodings for the up/down timer.
// Assumes: single-bit mode and direction inputs map directly onto these values.
package timer_pkg;

    typedef enum logic {
        PWM_TOGGLE = 1'b0,
        PWM_MATCH  = 1'b1
    } pwm_mode_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } count_dir_e;

endpackage

// File: rtl/timer_evt_sync.sv
// Module: synchronizes an asynchronous event level and emits a one-cycle
// pulse on each rising edge.
// Assumes: STAGES >= 2; the event level stays high or low for at least two clocks.
module timer_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_async,
    output logic evt_pulse
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the event level through the synchronizer chain and keep the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], evt_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge of the synchronized level.
    always_comb evt_pulse = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/timer_counter.sv
// Module: up/down counter with terminal-count detection, reload and event restart.
// Assumes: evt_restart is a single-cycle pulse; a restart overrides counting for one cycle.
module timer_counter
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  count_dir_e   dir,
    input  logic [W-1:0] load_val,
    input  logic         evt_restart,
    output logic [W-1:0] count,
    output logic         timeout_evt,
    output logic         counting,
    output logic         restart_busy
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic         at_terminal;
    logic [W-1:0] reload_val;

    // Terminal value depends on direction; reload value likewise.
    always_comb begin
        at_terminal = (dir == DIR_UP) ? (count == CNT_MAX) : (count == '0);
        reload_val  = (dir == DIR_UP) ? '0 : load_val;
        counting    = en && !restart_busy && !evt_restart;
        timeout_evt = counting && at_terminal;
    end

    // Count, reload at terminal, or restart on an event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count        <= '0;
            restart_busy <= 1'b0;
        end else if (evt_restart) begin
            count        <= reload_val;
            restart_busy <= 1'b1;
        end else begin
            restart_busy <= 1'b0;
            if (counting) begin
                if (at_terminal)
                    count <= reload_val;
                else if (dir == DIR_UP)
                    count <= count + W'(1);
                else
                    count <= count - W'(1);
            end
        end
    end

endmodule

// File: rtl/timer_pwm.sv
// Module: pulse-width output generator with toggle and match modes.
// Assumes: timeout_evt and counting come from the counter in the same cycle as count.
module timer_pwm
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pwm_mode_e    mode,
    input  logic         idle_lvl,
    input  logic [W-1:0] match_val,
    input  logic [W-1:0] count,
    input  logic         counting,
    input  logic         timeout_evt,
    output logic         pwm_out
);

    logic active_q;
    logic hit;

    // A match counts only in a counting cycle that is not a timeout.
    always_comb hit = counting && !timeout_evt && (count == match_val);

    // Track whether the output is away from its idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (mode == PWM_TOGGLE) begin
            if (timeout_evt)
                active_q <= ~active_q;
        end else begin
            if (timeout_evt)
                active_q <= 1'b0;
            else if (hit)
                active_q <= 1'b1;
        end
    end

    // Apply the idle polarity.
    always_comb pwm_out = idle_lvl ^ active_q;

endmodule

// File: rtl/timer_capture.sv
// Module: capture register with a sticky pending flag.
// Assumes: strobe is a single-cycle pulse; a new capture wins over a clear.
module timer_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         clr,
    input  logic [W-1:0] count,
    output logic [W-1:0] cap_value,
    output logic         pending
);

    // Latch the count on a strobe and keep the pending flag until it is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_value <= '0;
            pending   <= 1'b0;
        end else if (strobe) begin
            cap_value <= count;
            pending   <= 1'b1;
        end else if (clr) begin
            pending   <= 1'b0;
        end
    end

endmodule

// File: rtl/updn_pwm_timer.sv
// Module: up/down timer top. Joins the event synchronizer, the counter,
// the capture register and the output generator, and holds the timeout flag.
// Assumes: all inputs except event_in are synchronous to clk.
module updn_pwm_timer
    import timer_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         count_up,
    input  logic [W-1:0] load_val,
    input  logic         event_in,
    input  logic         evt_capture_en,
    input  logic         evt_reset_en,
    input  logic         clr_irq,
    input  logic         clr_cap,
    input  logic         pwm_match_mode,
    input  logic         pwm_idle_lvl,
    input  logic [W-1:0] match_val,
    output logic         pwm_out,
    output logic         timeout_flag,
    output logic         cap_pending,
    output logic [W-1:0] cap_value,
    output logic         cnt_rst_busy
);

    logic         evt_pulse;
    logic         evt_restart;
    logic         cap_strobe;
    logic [W-1:0] count;
    logic         timeout_evt;
    logic         counting;

    timer_evt_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_async (event_in),
        .evt_pulse (evt_pulse)
    );

    // Route the detected event to its enabled consumers.
    always_comb begin
        evt_restart = evt_pulse && evt_reset_en;
        cap_strobe  = evt_pulse && evt_capture_en;
    end

    timer_counter #(.W(W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .dir          (count_dir_e'(count_up)),
        .load_val     (load_val),
        .evt_restart  (evt_restart),
        .count        (count),
        .timeout_evt  (timeout_evt),
        .counting     (counting),
        .restart_busy (cnt_rst_busy)
    );

    timer_capture #(.W(W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (cap_strobe),
        .clr       (clr_cap),
        .count     (count),
        .cap_value (cap_value),
        .pending   (cap_pending)
    );

    timer_pwm #(.W(W)) u_pwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (pwm_mode_e'(pwm_match_mode)),
        .idle_lvl    (pwm_idle_lvl),
        .match_val   (match_val),
        .count       (count),
        .counting    (counting),
        .timeout_evt (timeout_evt),
        .pwm_out     (pwm_out)
    );

    // Sticky timeout flag; a new timeout wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            timeout_flag <= 1'b0;
        else if (timeout_evt)
            timeout_flag <= 1'b1;
        else if (clr_irq)
            timeout_flag <= 1'b0;
    end

endmodule

// File: rtl/timer_checker.sv
// Module: assertion checker for updn_pwm_timer, attached through bind.
// Assumes: it observes the top's ports and a few internal nets by name.
module timer_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         count_up,
    input logic [W-1:0] load_val,
    input logic         clr_irq,
    input logic         clr_cap,
    input logic         pwm_match_mode,
    input logic         pwm_idle_lvl,
    input logic         pwm_out,
    input logic         timeout_flag,
    input logic         cap_pending,
    input logic [W-1:0] cap_value,
    input logic         cnt_rst_busy,
    input logic [W-1:0] count,
    input logic         timeout_evt,
    input logic         evt_restart,
    input logic         cap_strobe
);

    assert_reload_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt && !count_up |=> count == $past(load_val));

    assert_reload_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt && count_up |=> count == '0);

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> timeout_flag);

    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag && !clr_irq |=> timeout_flag);

    assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_irq && !timeout_evt |=> !timeout_flag);

    assert_match_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_match_mode && timeout_evt |=> pwm_out == pwm_idle_lvl);

    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_match_mode && timeout_evt |=>
            (pwm_out ^ pwm_idle_lvl) != $past(pwm_out ^ pwm_idle_lvl));

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> cap_pending && cap_value == $past(count));

    assert_cap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_strobe |=> $stable(cap_value));

    assert_cap_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cap && !cap_strobe |=> !cap_pending);

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_restart |=> cnt_rst_busy && count == ($past(count_up) ? '0 : $past(load_val)));

    assert_busy_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_busy |=> !cnt_rst_busy);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_busy && !evt_restart |=> $stable(count));

endmodule

bind updn_pwm_timer timer_checker #(.W(W)) u_timer_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .count_up       (count_up),
    .load_val       (load_val),
    .clr_irq        (clr_irq),
    .clr_cap        (clr_cap),
    .pwm_match_mode (pwm_match_mode),
    .pwm_idle_lvl   (pwm_idle_lvl),
    .pwm_out        (pwm_out),
    .timeout_flag   (timeout_flag),
    .cap_pending    (cap_pending),
    .cap_value      (cap_value),
    .cnt_rst_busy   (cnt_rst_busy),
    .count          (count),
    .timeout_evt    (timeout_evt),
    .evt_restart    (evt_restart),
    .cap_strobe     (cap_strobe)
);

// File: tb/test_updn_pwm_timer.sv
// Bench for updn_pwm_timer with an 8-bit counter: a vector table of
// output-mode cases followed by directed tests.
module test_updn_pwm_timer;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         count_up = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         event_in = 1'b0;
    logic         evt_capture_en = 1'b0;
    logic         evt_reset_en = 1'b0;
    logic         clr_irq = 1'b0;
    logic         clr_cap = 1'b0;
    logic         pwm_match_mode = 1'b0;
    logic         pwm_idle_lvl = 1'b0;
    logic [W-1:0] match_val = '0;
    logic         pwm_out;
    logic         timeout_flag;
    logic         cap_pending;
    logic [W-1:0] cap_value;
    logic         cnt_rst_busy;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    updn_pwm_timer #(.W(W)) i_updn_pwm_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .count_up       (count_up),
        .load_val       (load_val),
        .event_in       (event_in),
        .evt_capture_en (evt_capture_en),
        .evt_reset_en   (evt_reset_en),
        .clr_irq        (clr_irq),
        .clr_cap        (clr_cap),
        .pwm_match_mode (pwm_match_mode),
        .pwm_idle_lvl   (pwm_idle_lvl),
        .match_val      (match_val),
        .pwm_out        (pwm_out),
        .timeout_flag   (timeout_flag),
        .cap_pending    (cap_pending),
        .cap_value      (cap_value),
        .cnt_rst_busy   (cnt_rst_busy)
    );

    // Vector: up, match mode, idle level, load, match, edges after enable, expected pwm_out.
    typedef struct packed {
        logic       up;
        logic       mode;
        logic       idle;
        logic [7:0] load;
        logic [7:0] match;
        logic [8:0] n;
        logic       exp;
    } vec_t;

    localparam int NV = 20;
    localparam logic [28:0] VECS [0:NV-1] = '{
        {1'b0, 1'b1, 1'b0, 8'd10, 8'd5,   9'd7,   1'b1},  // R3 match reached
        {1'b0, 1'b1, 1'b0, 8'd10, 8'd5,   9'd6,   1'b0},  // R3 one edge early
        {1'b0, 1'b1, 1'b0, 8'd10, 8'd5,   9'd11,  1'b1},  // R3 held
        {1'b0, 1'b1, 1'b0, 8'd10, 8'd5,   9'd12,  1'b0},  // R4 timeout ends pulse
        {1'b0, 1'b1, 1'b0, 8'd10, 8'd0,   9'd11,  1'b0},  // R4 coincident match
        {1'b0, 1'b1, 1'b1, 8'd10, 8'd0,   9'd12,  1'b1},  // R4 coincident, idle high
        {1'b0, 1'b1, 1'b0, 8'd10, 8'd10,  9'd2,   1'b1},  // R3 match at load value
        {1'b0, 1'b1, 1'b0, 8'd10, 8'd11,  9'd11,  1'b0},  // R4 never reached
        {1'b0, 1'b1, 1'b1, 8'd10, 8'd5,   9'd8,   1'b0},  // R6 inverted polarity
        {1'b1, 1'b1, 1'b0, 8'd0,  8'd100, 9'd101, 1'b1},  // R3 up count
        {1'b1, 1'b1, 1'b0, 8'd0,  8'd100, 9'd100, 1'b0},  // R3 up, early
        {1'b1, 1'b1, 1'b0, 8'd0,  8'd100, 9'd255, 1'b1},  // R3 up, held to end
        {1'b1, 1'b1, 1'b0, 8'd0,  8'd100, 9'd256, 1'b0},  // R4 up timeout
        {1'b0, 1'b0, 1'b0, 8'd10, 8'd0,   9'd1,   1'b1},  // R5 first toggle
        {1'b0, 1'b0, 1'b0, 8'd10, 8'd0,   9'd11,  1'b1},  // R5 held
        {1'b0, 1'b0, 1'b0, 8'd10, 8'd0,   9'd12,  1'b0},  // R5 second toggle
        {1'b0, 1'b0, 1'b1, 8'd10, 8'd0,   9'd12,  1'b1},  // R6 toggle, idle high
        {1'b0, 1'b0, 1'b1, 8'd10, 8'd0,   9'd23,  1'b0},  // R6 third toggle
        {1'b1, 1'b0, 1'b0, 8'd0,  8'd0,   9'd255, 1'b0},  // R5 up, before wrap
        {1'b1, 1'b0, 1'b0, 8'd0,  8'd0,   9'd256, 1'b1}   // R5 up, wrap toggles
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b0;
        event_in = 1'b0;
        clr_irq = 1'b0;
        clr_cap = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        // R9: reset state.
        do_reset();
        check("R9", "pwm_out", 32'(pwm_out), 0);
        check("R9", "timeout_flag", 32'(timeout_flag), 0);
        check("R9", "cap_pending", 32'(cap_pending), 0);
        check("R9", "cap_value", 32'(cap_value), 0);
        check("R9", "cnt_rst_busy", 32'(cnt_rst_busy), 0);

        // Vector table of output-mode cases.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            do_reset();
            count_up       = v.up;
            pwm_match_mode = v.mode;
            pwm_idle_lvl   = v.idle;
            load_val       = v.load;
            match_val      = v.match;
            en             = 1'b1;
            step(int'(v.n));
            check(v.mode ? "R3/R4" : "R5", $sformatf("pwm_out vector %0d", i),
                  32'(pwm_out), 32'(v.exp));
        end
        pwm_match_mode = 1'b0;
        pwm_idle_lvl   = 1'b0;

        // R1: up-count timeout at all ones.
        do_reset();
        count_up = 1'b1;
        en = 1'b1;
        step(255);
        check("R1", "up flag before terminal", 32'(timeout_flag), 0);
        step(1);
        check("R1", "up flag at terminal", 32'(timeout_flag), 1);

        // R1/R2: down count from load 5, clear, and sticky flag.
        do_reset();
        count_up = 1'b0;
        load_val = 8'd5;
        en = 1'b1;
        step(1);
        check("R1", "down flag at zero", 32'(timeout_flag), 1);
        clr_irq = 1'b1;
        step(1);
        clr_irq = 1'b0;
        check("R2", "flag cleared", 32'(timeout_flag), 0);
        step(4);
        check("R1", "down flag before reload expires", 32'(timeout_flag), 0);
        step(1);
        check("R1", "down flag after load counted out", 32'(timeout_flag), 1);
        step(3);
        check("R2", "flag sticky", 32'(timeout_flag), 1);

        // R7: capture with up count; count after edge k equals k.
        do_reset();
        count_up = 1'b1;
        evt_capture_en = 1'b1;
        en = 1'b1;
        step(10);
        event_in = 1'b1;
        step(2);
        check("R7", "pending before capture edge", 32'(cap_pending), 0);
        step(1);
        check("R7", "pending after capture", 32'(cap_pending), 1);
        check("R7", "captured count", 32'(cap_value), 12);
        step(5);
        check("R7", "held level captures once", 32'(cap_value), 12);
        event_in = 1'b0;
        clr_cap = 1'b1;
        step(1);
        clr_cap = 1'b0;
        check("R7", "pending cleared", 32'(cap_pending), 0);
        evt_capture_en = 1'b0;
        step(2);
        event_in = 1'b1;
        step(5);
        check("R7", "no capture when disabled", 32'(cap_pending), 0);
        check("R7", "value kept when disabled", 32'(cap_value), 12);
        event_in = 1'b0;

        // R8: event reset with capture, up count.
        do_reset();
        count_up = 1'b1;
        evt_capture_en = 1'b1;
        evt_reset_en = 1'b1;
        en = 1'b1;
        step(20);
        event_in = 1'b1;
        step(2);
        check("R8", "busy before event", 32'(cnt_rst_busy), 0);
        step(1);
        check("R8", "busy during reset", 32'(cnt_rst_busy), 1);
        check("R7", "capture before reset", 32'(cap_value), 22);
        step(1);
        check("R8", "busy one cycle", 32'(cnt_rst_busy), 0);
        event_in = 1'b0;
        step(6);
        event_in = 1'b1;
        step(3);
        check("R8", "count restarted and held", 32'(cap_value), 8);
        check("R8", "busy on second event", 32'(cnt_rst_busy), 1);
        event_in = 1'b0;
        evt_capture_en = 1'b0;
        evt_reset_en = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule